// File: doc/BRIEF.md
# Split instruction/data TLB address translator

This block turns a virtual address into a physical address for one access at a time. It holds two direct-mapped translation tables: one for instruction fetches and one for data loads and stores. Each table has 64 sets, and each set holds a match word and a translate word. Every request reads both tables at the same set. When the two translate words name the same physical page, their rights are merged. The result is a physical address, the granted read, write and execute rights, and a fault code that separates a protection fault from a table miss, and an instruction access from a data access.

A write port loads table words one at a time. A fault that is not a probe records the faulting virtual address in a fault-address register and invalidates the load-linked reservation. When translation is switched off for a request, the address passes through unchanged with every right granted.

A two-state controller issues the response. It sits in IDLE until a request arrives and then moves to REPLY (transition ACCEPT). It stays in REPLY while requests keep arriving back to back (transition CHAIN). With no new request it returns to IDLE (transition DRAIN). The registered results and the `rsp_valid` pulse are valid while the controller is in REPLY.

Top module: `xlat_split_tlb`

## Requirements
- R1: The set index is virtual address bits [18:13]. The same index reads one instruction-table set and one data-table set.
- R2: A table hits only when its match word bit 0 (valid) is 1 and match word bits [31:13] equal virtual address bits [31:13].
- R3: When bits [31:13] of the two translate words differ, a fetch treats the data-table entry as all zero, and a load or store treats the instruction-table entry as all zero.
- R4: Rights output bits are bit0 read, bit1 write and bit2 execute. Execute comes from the instruction translate word: bit 7 in supervisor mode, bit 6 in user mode. Read comes from the data translate word: bit 8 in supervisor mode, bit 6 in user mode. Write comes from the data translate word: bit 9 in supervisor mode, bit 7 in user mode. Each right is granted only if its own table hit.
- R5: With translation on, the physical address is the OR of bits [31:13] of both translate words, followed by virtual address bits [12:0].
- R6: Access kind is 0 fetch, 1 load, 2 store. Fault codes are: 0 none, 1 instruction miss, 2 data miss, 3 instruction protection, 4 data protection. The code is 0 when the needed right is granted. It is 3 or 4 when the needed table hit but the right is missing. Every other failure gives 1 or 2.
- R7: With `req_mmu_on` low, the physical address equals the virtual address, the rights are 3'b111 and the fault code is 0.
- R8: A faulting request without probe loads the fault-address register with its virtual address and sets the reservation to all ones. Otherwise `ll_set` loads the reservation from `ll_addr`.
- R9: A probe request reports its fault code but leaves the fault-address and reservation registers unchanged.
- R10: Reset clears every table word and the fault-address register, and sets the reservation to all ones. A request gives a one-cycle `rsp_valid` pulse with its results on the next cycle. A table write is seen by a request made in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table word write enable |
| cfg_dside | input | 1 | 0 selects the instruction table, 1 selects the data table |
| cfg_xword | input | 1 | 0 writes the match word, 1 writes the translate word |
| cfg_set | input | 6 | Set to write |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_super | input | 1 | Supervisor mode |
| req_mmu_on | input | 1 | Translation enable |
| req_probe | input | 1 | Probe: report only, no register side effects |
| ll_set | input | 1 | Load the reservation address |
| ll_addr | input | 32 | New reservation address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | Granted rights {exec, write, read} |
| rsp_fault | output | 3 | Fault code |
| eear_q | output | 32 | Fault-address register |
| resv_q | output | 32 | Reservation address register |

## Verification
The hardest case to reach is a set whose two translate words name different physical pages. Only then does the dropping of the unused entry decide both the physical address and the rights. The stimulus programs one set with different pages in the two tables, then fetches and loads through it. The result then shows only one table's page and rights. Another set keeps a valid instruction entry beside a data entry whose valid bit is clear. Loading through that set shows that a miss takes priority over a protection fault when only the other table hits.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_IMISS = 3'd1,
        FLT_DMISS = 3'd2,
        FLT_IPROT = 3'd3,
        FLT_DPROT = 3'd4
    } fault_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } rsp_state_e;

    // translate word right bits
    localparam int XB_UX = 6;
    localparam int XB_SX = 7;
    localparam int DB_UR = 6;
    localparam int DB_UW = 7;
    localparam int DB_SR = 8;
    localparam int DB_SW = 9;

    // rights vector positions
    localparam int RT_R = 0;
    localparam int RT_W = 1;
    localparam int RT_X = 2;
endpackage

// File: rtl/xlat_tlb_bank.sv
module xlat_tlb_bank #(
    parameter int WORD_W   = 32,
    parameter int SET_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_xword,
    input  logic [SET_BITS-1:0] wr_set,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [SET_BITS-1:0] rd_set,
    output logic [WORD_W-1:0]   rd_match,
    output logic [WORD_W-1:0]   rd_xlate
);
    localparam int SETS = 1 << SET_BITS;

    logic [WORD_W-1:0] match_mem [SETS];
    logic [WORD_W-1:0] xlate_mem [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                match_mem[i] <= '0;
                xlate_mem[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_xword) xlate_mem[wr_set] <= wr_data;
            else          match_mem[wr_set] <= wr_data;
        end
    end

    assign rd_match = match_mem[rd_set];
    assign rd_xlate = xlate_mem[rd_set];
endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
    import xlat_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        kind,
    input  logic              supv,
    input  logic              mmu_on,
    input  logic [ADDR_W-1:0] imr,
    input  logic [ADDR_W-1:0] itr,
    input  logic [ADDR_W-1:0] dmr,
    input  logic [ADDR_W-1:0] dtr,
    output logic [ADDR_W-1:0] paddr,
    output logic [2:0]        rights,
    output fault_e            fault
);
    localparam int VPN_LO = PAGE_BITS;
    localparam int VPN_HI = ADDR_W - 1;

    logic [ADDR_W-1:0] im, it, dm, dt, merged;
    logic              is_fetch, hit_i, hit_d;
    logic [2:0]        need, valid, grant;

    wire unused_words = ^{imr[PAGE_BITS-1:1], dmr[PAGE_BITS-1:1]};

    always_comb begin
        is_fetch = (kind == ACC_FETCH);
        need     = is_fetch ? 3'b100 : (kind == ACC_STORE) ? 3'b010 : 3'b001;
        im = imr; it = itr; dm = dmr; dt = dtr;
        // drop the entry this access does not need when pages disagree
        if (itr[VPN_HI:VPN_LO] != dtr[VPN_HI:VPN_LO]) begin
            if (is_fetch) begin dm = '0; dt = '0; end
            else          begin im = '0; it = '0; end
        end
        hit_i = im[0] && (im[VPN_HI:VPN_LO] == vaddr[VPN_HI:VPN_LO]);
        hit_d = dm[0] && (dm[VPN_HI:VPN_LO] == vaddr[VPN_HI:VPN_LO]);
        valid = {hit_i, hit_d, hit_d};
        grant[RT_X] = (supv ? it[XB_SX] : it[XB_UX]) & hit_i;
        grant[RT_R] = (supv ? dt[DB_SR] : dt[DB_UR]) & hit_d;
        grant[RT_W] = (supv ? dt[DB_SW] : dt[DB_UW]) & hit_d;
        merged = it | dt;
        if (!mmu_on) begin
            paddr  = vaddr;
            rights = 3'b111;
            fault  = FLT_NONE;
        end else begin
            paddr  = {merged[VPN_HI:VPN_LO], vaddr[PAGE_BITS-1:0]};
            rights = grant;
            if (|(need & grant))      fault = FLT_NONE;
            else if (|(need & valid)) fault = is_fetch ? FLT_IPROT : FLT_DPROT;
            else                      fault = is_fetch ? FLT_IMISS : FLT_DMISS;
        end
    end
endmodule

// File: rtl/xlat_split_tlb.sv
module xlat_split_tlb
    import xlat_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int SET_BITS  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_dside,
    input  logic                cfg_xword,
    input  logic [SET_BITS-1:0] cfg_set,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_vaddr,
    input  logic [1:0]          req_kind,
    input  logic                req_super,
    input  logic                req_mmu_on,
    input  logic                req_probe,
    input  logic                ll_set,
    input  logic [ADDR_W-1:0]   ll_addr,
    output logic                rsp_valid,
    output logic [ADDR_W-1:0]   rsp_paddr,
    output logic [2:0]          rsp_rights,
    output logic [2:0]          rsp_fault,
    output logic [ADDR_W-1:0]   eear_q,
    output logic [ADDR_W-1:0]   resv_q
);
    localparam int NBANK = 2;   // 0 instruction, 1 data

    rsp_state_e state_q, state_d;
    logic [SET_BITS-1:0] rd_set;
    logic [ADDR_W-1:0]   mw [NBANK];
    logic [ADDR_W-1:0]   tw [NBANK];
    logic [ADDR_W-1:0]   lk_paddr;
    logic [2:0]          lk_rights;
    fault_e              lk_fault;

    assign rd_set = req_vaddr[PAGE_BITS +: SET_BITS];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        xlat_tlb_bank #(.WORD_W(ADDR_W), .SET_BITS(SET_BITS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_dside == 1'(b))),
            .wr_xword (cfg_xword),
            .wr_set   (cfg_set),
            .wr_data  (cfg_wdata),
            .rd_set   (rd_set),
            .rd_match (mw[b]),
            .rd_xlate (tw[b])
        );
    end

    xlat_lookup #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_lookup (
        .vaddr  (req_vaddr),
        .kind   (req_kind),
        .supv   (req_super),
        .mmu_on (req_mmu_on),
        .imr    (mw[0]),
        .itr    (tw[0]),
        .dmr    (mw[1]),
        .dtr    (tw[1]),
        .paddr  (lk_paddr),
        .rights (lk_rights),
        .fault  (lk_fault)
    );

    // next-state: ACCEPT, CHAIN, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_REPLY;
            ST_REPLY: state_d = req_valid ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_paddr  <= '0;
            rsp_rights <= '0;
            rsp_fault  <= FLT_NONE;
            eear_q     <= '0;
            resv_q     <= '1;
        end else begin
            if (req_valid) begin
                rsp_paddr  <= lk_paddr;
                rsp_rights <= lk_rights;
                rsp_fault  <= lk_fault;
            end
            if (req_valid && (lk_fault != FLT_NONE) && !req_probe) begin
                eear_q <= req_vaddr;
                resv_q <= '1;
            end else if (ll_set) begin
                resv_q <= ll_addr;
            end
        end
    end

    assign rsp_valid = (state_q == ST_REPLY);
endmodule

// File: rtl/xlat_split_tlb_chk.sv
module xlat_split_tlb_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              req_mmu_on,
    input logic              req_probe,
    input logic              ll_set,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [2:0]        rsp_rights,
    input logic [2:0]        rsp_fault,
    input logic [ADDR_W-1:0] eear_q,
    input logic [ADDR_W-1:0] resv_q
);
    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0]));
    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mmu_on) |=>
            (rsp_paddr == $past(req_vaddr) && rsp_rights == 3'b111 && rsp_fault == 3'd0));
    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault <= 3'd4);
    assert_success_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd0) |-> rsp_rights != 3'b000);
    assert_fault_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_probe) |=>
            (rsp_fault == 3'd0 || (eear_q == $past(req_vaddr) && resv_q == '1)));
    assert_probe_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_probe && !ll_set) |=> ($stable(eear_q) && $stable(resv_q)));
endmodule

bind xlat_split_tlb xlat_split_tlb_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_mmu_on (req_mmu_on),
    .req_probe  (req_probe),
    .ll_set     (ll_set),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_rights (rsp_rights),
    .rsp_fault  (rsp_fault),
    .eear_q     (eear_q),
    .resv_q     (resv_q)
);

// File: tb/tb_xlat_split_tlb.sv
`timescale 1ns/1ps
module tb_xlat_split_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_dside = 1'b0, cfg_xword = 1'b0;
    logic [5:0]  cfg_set = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_super = 1'b0, req_mmu_on = 1'b0, req_probe = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        ll_set = 1'b0;
    logic [31:0] ll_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr, eear_q, resv_q;
    logic [2:0]  rsp_rights, rsp_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xlat_split_tlb dut (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic        sup;
        logic        mmu;
        logic [31:0] pa;
        logic [2:0]  rt;
        logic [2:0]  flt;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0140A123, 2'd0, 1'b0, 1'b1, 32'h2468A123, 3'b101, 3'd0, 8'd4},  // R4 user fetch, merged
        '{32'h0140A123, 2'd2, 1'b0, 1'b1, 32'h2468A123, 3'b101, 3'd4, 8'd6},  // R6 user store -> data prot
        '{32'h0140A123, 2'd2, 1'b1, 1'b1, 32'h2468A123, 3'b011, 3'd0, 8'd4},  // R4 super store
        '{32'h0140A123, 2'd0, 1'b1, 1'b1, 32'h2468A123, 3'b011, 3'd3, 8'd6},  // R6 super fetch -> inst prot
        '{32'h00212456, 2'd0, 1'b0, 1'b1, 32'h01554456, 3'b100, 3'd0, 8'd3},  // R3 fetch keeps I page
        '{32'h00212456, 2'd1, 1'b0, 1'b1, 32'h01776456, 3'b011, 3'd0, 8'd3},  // R3 load keeps D page
        '{32'h000181FF, 2'd1, 1'b1, 1'b1, 32'h00EEE1FF, 3'b100, 3'd2, 8'd2},  // R2 invalid D -> data miss
        '{32'h000181FF, 2'd0, 1'b0, 1'b1, 32'h00EEE1FF, 3'b100, 3'd0, 8'd2},  // R2 valid I hit
        '{32'h0340A010, 2'd0, 1'b0, 1'b1, 32'h2468A010, 3'b000, 3'd1, 8'd1},  // R1 same set, tag differs
        '{32'h000280AB, 2'd1, 1'b0, 1'b1, 32'h000000AB, 3'b000, 3'd2, 8'd5},  // R5 empty set
        '{32'hDEADBEEF, 2'd2, 1'b0, 1'b0, 32'hDEADBEEF, 3'b111, 3'd0, 8'd7}   // R7 bypass
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr_entry(input logic dside, input logic xword, input logic [5:0] set,
                            input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b0; ll_set = 1'b0;
        cfg_we = 1'b1; cfg_dside = dside; cfg_xword = xword; cfg_set = set; cfg_wdata = data;
    endtask

    task automatic do_req(input logic [31:0] va, input logic [1:0] kind, input logic sup,
                          input logic mmu, input logic probe);
        @(negedge clk);
        cfg_we = 1'b0; ll_set = 1'b0;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_super = sup;
        req_mmu_on = mmu; req_probe = probe;
        @(negedge clk);
        req_valid = 1'b0; req_probe = 1'b0;
    endtask

    task automatic load_resv(input logic [31:0] a);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        ll_set = 1'b1; ll_addr = a;
        @(negedge clk);
        ll_set = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        logic [31:0] eear_before;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R10 reset eear", eear_q, 32'h0);
        check("R10 reset resv", resv_q, 32'hFFFFFFFF);
        rst_n = 1'b1;

        // R10 tables empty after reset: fetch at 0 misses
        do_req(32'h0, 2'd0, 1'b0, 1'b1, 1'b0);
        check("R10 empty fetch fault", {29'b0, rsp_fault}, 32'd1);
        check("R10 response pulse high", {31'b0, rsp_valid}, 32'd1);
        @(negedge clk);
        check("R10 response pulse ends", {31'b0, rsp_valid}, 32'd0);

        // program sets 5, 9, 12
        wr_entry(1'b0, 1'b0, 6'd5,  32'h0140A001);
        wr_entry(1'b0, 1'b1, 6'd5,  32'h2468A040);
        wr_entry(1'b1, 1'b0, 6'd5,  32'h0140A001);
        wr_entry(1'b1, 1'b1, 6'd5,  32'h2468A340);
        wr_entry(1'b0, 1'b0, 6'd9,  32'h00212001);
        wr_entry(1'b0, 1'b1, 6'd9,  32'h015540C0);
        wr_entry(1'b1, 1'b0, 6'd9,  32'h00212001);
        wr_entry(1'b1, 1'b1, 6'd9,  32'h017760C0);
        wr_entry(1'b0, 1'b0, 6'd12, 32'h00018001);
        wr_entry(1'b0, 1'b1, 6'd12, 32'h00EEE0C0);
        wr_entry(1'b1, 1'b0, 6'd12, 32'h00018000);
        wr_entry(1'b1, 1'b1, 6'd12, 32'h00EEE3C0);

        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].va, VECS[i].kind, VECS[i].sup, VECS[i].mmu, 1'b0);
            checks++;
            if (rsp_paddr !== VECS[i].pa || rsp_rights !== VECS[i].rt ||
                rsp_fault !== VECS[i].flt || rsp_valid !== 1'b1) begin
                fails++;
                $display("FAIL vector %0d (R%0d): actual pa=%h rt=%b flt=%0d v=%b expected pa=%h rt=%b flt=%0d v=1",
                         i, VECS[i].req, rsp_paddr, rsp_rights, rsp_fault, rsp_valid,
                         VECS[i].pa, VECS[i].rt, VECS[i].flt);
            end
            if (VECS[i].flt != 3'd0) begin
                check("R8 vector fault address", eear_q, VECS[i].va);
                check("R8 vector reservation cleared", resv_q, 32'hFFFFFFFF);
            end
        end

        // R9 probe: fault reported, registers untouched
        load_resv(32'h00001000);
        check("R8 reservation load", resv_q, 32'h00001000);
        eear_before = eear_q;
        do_req(32'h0340A010, 2'd0, 1'b0, 1'b1, 1'b1);
        check("R9 probe fault code", {29'b0, rsp_fault}, 32'd1);
        check("R9 probe keeps eear", eear_q, eear_before);
        check("R9 probe keeps resv", resv_q, 32'h00001000);

        // R8 same access without probe
        do_req(32'h0340A010, 2'd0, 1'b0, 1'b1, 1'b0);
        check("R8 fault eear", eear_q, 32'h0340A010);
        check("R8 fault resv", resv_q, 32'hFFFFFFFF);

        // R10 write seen by request in the very next cycle
        wr_entry(1'b0, 1'b1, 6'd30, 32'h00100040);
        wr_entry(1'b0, 1'b0, 6'd30, 32'h0003C001);
        do_req(32'h0003C000, 2'd0, 1'b0, 1'b1, 1'b0);
        check("R10 next-cycle write fault", {29'b0, rsp_fault}, 32'd0);
        check("R10 next-cycle write paddr", rsp_paddr, 32'h00100000);
        check("R3 set 30 rights", {29'b0, rsp_rights}, 32'd4);

        finish_run();
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule